// File: doc/BRIEF.md
# SDRAM Command Decoder with Per-Bank Row Tracking

This block sits next to an SDRAM pin interface and watches the command pins on every rising clock edge. It turns chip select, the three strobe pins, clock enable, the address bus and the bank address into one command code. For each bank it keeps whether the bank is open and which row is open. A memory controller, a protocol monitor or a memory model can use it to know the bank state without decoding the pins itself.

Address bit 8 has two meanings. On a read or write it asks for the bank to close by itself once the burst is over. On a precharge it widens the precharge to every bank. The delay before a self-closing bank goes idle depends on the burst length input. Illegal accesses raise a single-cycle error flag and do not change the bank state. The data path, refresh timing, mode-register programming and self-refresh are outside this block.

All command outputs are registered. They show the command sampled at the last rising edge.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: When `cs_ni` is high at an enabled edge, `cmd_o` shows NOP (0) after that edge and no bank state changes.
- R2: With `cs_ni` low, the pin pattern {ras_ni,cas_ni,we_ni} decodes as follows: 011 = activate (code 1), 101 = read (code 2), 100 = write (code 3), 010 = precharge (code 4, or 5 when address bit 8 is high). Patterns 111, 110 and 000 decode as NOP (0).
- R3: On activate, `row_o` takes the full 12-bit address. On read or write, `col_o` takes {addr[9], addr[7:0]} and `ap_o` takes addr[8]. `bank_o` takes `ba_i` on every non-NOP command. These outputs hold their values across NOP cycles.
- R4: Pattern 001 with `cke_i` high at the same edge decodes as auto-refresh (code 6) and leaves every bank idle. With `cke_i` low at that edge the pattern decodes as NOP.
- R5: An activate to an idle bank opens that bank (`bank_open_o[ba]` = 1) and stores the row in the bank's slice of `open_rows_o`, at bits [12*ba +: 12].
- R6: An activate to a bank that is open, including one waiting to close by itself, makes `err_o` high for one cycle and leaves the bank state and the stored row unchanged.
- R7: A read or write to an idle bank, or to a bank already waiting to close by itself, makes `err_o` high for one cycle and changes no bank state.
- R8: A precharge (code 4) closes the addressed bank and cancels any pending self-close on it. A precharge with bit 8 high (code 5) closes all banks. A precharge to an idle bank raises no error.
- R9: A legal read or write with addr[8] high starts a self-close. The bank goes idle after N more enabled edges, where N = 1, 2, 4, 4 for `burst_len_i` = 0, 1, 2, 3 (2, 4 or 8 beats at two beats per clock; code 3 is treated as 8 beats).
- R10: After an edge that samples `cke_i` low, the next edge decodes NOP. At that next edge all bank state, including self-close countdowns, holds, and the registered address outputs hold.
- R11: After reset, `cmd_o` = 0, `err_o` = 0, every bank is idle and every stored row is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| addr_i | input | 12 | Multiplexed row/column address; bit 8 is the precharge option |
| ba_i | input | 2 | Bank select |
| burst_len_i | input | 2 | Burst length code: 0 = 2 beats, 1 = 4, 2 = 8, 3 = 8 |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 2 | Bank of the last non-NOP command |
| row_o | output | 12 | Row of the last activate |
| col_o | output | 9 | Column of the last read or write |
| ap_o | output | 1 | Self-close flag of the last command |
| err_o | output | 1 | One-cycle protocol error pulse |
| bank_open_o | output | 4 | Open flag for each bank |
| open_rows_o | output | 48 | Open row for each bank, 12 bits per bank |

## Verification
The bank flags and stored rows are outputs, so a wrong open/idle decision shows up at the edge after the command that caused it. A countdown that is off by one moves the falling edge of `bank_open_o` by one cycle after a self-closing access. This is compared cycle by cycle for every burst code. A wrong internal state that is not visible yet shows up at the next access to that bank: an `err_o` pulse where none was expected, or a missing one. Clock-enable gating is checked by whether a countdown pauses for exactly one edge.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6
  } cmd_e;
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_pkg::*;
(
  input  logic gate_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic cke_i,
  input  logic opt_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!gate_i && !cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = opt_i ? CMD_PREA : CMD_PRE;
        3'b001:  cmd_o = cke_i ? CMD_REF : CMD_NOP; // cke low here means self refresh, not handled
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot
  import sdr_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             sel_i,
  input  cmd_e             cmd_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [CNT_W-1:0] burst_cyc_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             err_o
);
  logic             open_q, closing_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;
  logic             is_rw;

  assign is_rw = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  assign err_o = sel_i && (((cmd_i == CMD_ACT) && open_q) ||
                           (is_rw && (!open_q || closing_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      closing_q <= 1'b0;
      cnt_q     <= '0;
      row_q     <= '0;
    end else if (adv_i) begin
      if ((cmd_i == CMD_REF) || (cmd_i == CMD_PREA) || ((cmd_i == CMD_PRE) && sel_i)) begin
        open_q    <= 1'b0;
        closing_q <= 1'b0;
      end else if ((cmd_i == CMD_ACT) && sel_i && !open_q) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (is_rw && sel_i && open_q && !closing_q && ap_i) begin
        closing_q <= 1'b1;
        cnt_q     <= burst_cyc_i;
      end else if (closing_q) begin
        if (cnt_q <= 1) begin
          open_q    <= 1'b0;
          closing_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;
endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
  import sdr_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 8,
  localparam int NB    = 1 << BANK_W,
  localparam int COL_W = AP_BIT + 1,
  localparam int CNT_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                ras_ni,
  input  logic                cas_ni,
  input  logic                we_ni,
  input  logic                cke_i,
  input  logic [ROW_W-1:0]    addr_i,
  input  logic [BANK_W-1:0]   ba_i,
  input  logic [1:0]          burst_len_i,
  output logic [2:0]          cmd_o,
  output logic [BANK_W-1:0]   bank_o,
  output logic [ROW_W-1:0]    row_o,
  output logic [COL_W-1:0]    col_o,
  output logic                ap_o,
  output logic                err_o,
  output logic [NB-1:0]       bank_open_o,
  output logic [NB*ROW_W-1:0] open_rows_o
);
  logic             cke_q;
  cmd_e             cmd_d, cmd_q;
  logic [NB-1:0]    err_v;
  logic [CNT_W-1:0] burst_cyc;
  logic             is_rw;

  // beats/2 clocks; the reserved code behaves as 8 beats
  assign burst_cyc = (burst_len_i == 2'd3) ? CNT_W'(4) : CNT_W'(1) << burst_len_i;
  assign is_rw     = (cmd_d == CMD_RD) || (cmd_d == CMD_WR);

  sdr_cmd_decode u_dec (
    .gate_i (!cke_q),
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .cke_i  (cke_i),
    .opt_i  (addr_i[AP_BIT]),
    .cmd_o  (cmd_d)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdr_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .adv_i       (cke_q),
      .sel_i       (ba_i == BANK_W'(b)),
      .cmd_i       (cmd_d),
      .ap_i        (addr_i[AP_BIT]),
      .row_i       (addr_i),
      .burst_cyc_i (burst_cyc),
      .open_o      (bank_open_o[b]),
      .row_o       (open_rows_o[b*ROW_W +: ROW_W]),
      .err_o       (err_v[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q  <= 1'b1;
      cmd_q  <= CMD_NOP;
      err_q_reset();
    end else begin
      cke_q <= cke_i;
      cmd_q <= cmd_d;
      err_o <= |err_v;
      if (cmd_d != CMD_NOP) begin
        bank_o <= ba_i;
        ap_o   <= is_rw & addr_i[AP_BIT];
      end
      if (cmd_d == CMD_ACT) row_o <= addr_i;
      if (is_rw) col_o <= {addr_i[AP_BIT+1], addr_i[AP_BIT-1:0]};
    end
  end

  task automatic err_q_reset();
    err_o  <= 1'b0;
    bank_o <= '0;
    ap_o   <= 1'b0;
    row_o  <= '0;
    col_o  <= '0;
  endtask

  assign cmd_o = cmd_q;
endmodule

// File: rtl/sdr_cmd_tracker_chk.sv
module sdr_cmd_tracker_chk #(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  localparam int NB    = 1 << BANK_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_ni,
  input logic                cke_i,
  input logic [ROW_W-1:0]    addr_i,
  input logic [2:0]          cmd_o,
  input logic [BANK_W-1:0]   bank_o,
  input logic [ROW_W-1:0]    row_o,
  input logic [COL_W-1:0]    col_o,
  input logic                err_o,
  input logic [NB-1:0]       bank_open_o,
  input logic [NB*ROW_W-1:0] open_rows_o
);
  assert_cs_nop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cmd_o == 3'd0));

  assert_col_pick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == 3'd2) || (cmd_o == 3'd3)) |-> (col_o == {$past(addr_i[9]), $past(addr_i[7:0])}));

  assert_ref_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd6) |-> (bank_open_o == '0));

  assert_act_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == 3'd1) && !err_o) |-> (bank_open_o[bank_o] && (open_rows_o[bank_o*ROW_W +: ROW_W] == row_o)));

  assert_act_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == 3'd1) && err_o) |-> $stable(open_rows_o));

  assert_rw_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cmd_o == 3'd2) || (cmd_o == 3'd3)) && !err_o) |-> (((($past(bank_open_o)) >> bank_o) & NB'(1)) != '0));

  assert_prea_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd5) |-> (bank_open_o == '0));

  assert_gate_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> ##1 ((cmd_o == 3'd0) && $stable(bank_open_o)));
endmodule

bind sdr_cmd_tracker sdr_cmd_tracker_chk #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .cke_i       (cke_i),
  .addr_i      (addr_i),
  .cmd_o       (cmd_o),
  .bank_o      (bank_o),
  .row_o       (row_o),
  .col_o       (col_o),
  .err_o       (err_o),
  .bank_open_o (bank_open_o),
  .open_rows_o (open_rows_o)
);

// File: tb/sdr_cmd_tracker_tb_top.sv
module sdr_cmd_tracker_tb_top;
  localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_PRE = 3'b010, P_REF = 3'b001, P_NOP = 3'b111;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [11:0] addr = '0;
  logic [1:0]  ba = '0, bl = '0;
  logic [2:0]  cmd;
  logic [1:0]  bank;
  logic [11:0] row;
  logic [8:0]  col;
  logic        ap, err;
  logic [3:0]  bopen;
  logic [47:0] rows;

  int n_chk = 0, n_bad = 0;

  bit          m_open [4];
  bit          m_cls  [4];
  int          m_cnt  [4];
  logic [11:0] m_row  [4];
  bit          m_ckep;
  int          e_cmd;
  bit          e_err, e_ap;
  logic [1:0]  e_bank;
  logic [11:0] e_row;
  logic [8:0]  e_col;
  string       tag;

  always #10 clk = ~clk;

  sdr_cmd_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .cke_i(cke), .addr_i(addr), .ba_i(ba), .burst_len_i(bl),
    .cmd_o(cmd), .bank_o(bank), .row_o(row), .col_o(col), .ap_o(ap),
    .err_o(err), .bank_open_o(bopen), .open_rows_o(rows)
  );

  task automatic chk(input bit ok, input string t, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_rows();
    logic [47:0] v;
    for (int b = 0; b < 4; b++) v[b*12 +: 12] = m_row[b];
    return v;
  endfunction

  function automatic logic [3:0] exp_open();
    logic [3:0] v;
    for (int b = 0; b < 4; b++) v[b] = m_open[b];
    return v;
  endfunction

  function automatic int decode(bit gated, logic c, logic [2:0] p, logic k, logic a8);
    if (gated || c) return 0;
    case (p)
      P_ACT: return 1;
      P_RD:  return 2;
      P_WR:  return 3;
      P_PRE: return a8 ? 5 : 4;
      P_REF: return k ? 6 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic model(logic c, logic [2:0] p, logic k, logic [11:0] a, logic [1:0] b, logic [1:0] l);
    bit gated = !m_ckep;
    int cc;
    bit any_cls = 0;
    m_ckep = k;
    cc = decode(gated, c, p, k, a[8]);
    e_cmd = cc;
    e_err = 0;
    for (int i = 0; i < 4; i++) any_cls |= m_cls[i];
    if (gated) tag = "R10";
    else if (c) tag = "R1";
    else if (cc == 6 || (p == P_REF && !k)) tag = "R4";
    else if (cc == 4 || cc == 5) tag = "R8";
    else if (cc == 1) tag = m_open[b] ? "R6" : "R5";
    else if (cc == 2 || cc == 3) tag = (!m_open[b] || m_cls[b]) ? "R7" : (a[8] ? "R9" : "R2");
    else tag = any_cls ? "R9" : "R2";
    if (gated) return;
    if (cc == 1 && m_open[b]) e_err = 1;
    if ((cc == 2 || cc == 3) && (!m_open[b] || m_cls[b])) e_err = 1;
    for (int i = 0; i < 4; i++) begin
      if (cc == 5 || cc == 6 || (cc == 4 && i == b)) begin
        m_open[i] = 0; m_cls[i] = 0;
      end else if (i == b && cc == 1 && !m_open[i]) begin
        m_open[i] = 1; m_row[i] = a;
      end else if (i == b && (cc == 2 || cc == 3) && m_open[i] && !m_cls[i] && a[8]) begin
        m_cls[i] = 1; m_cnt[i] = (l == 2'd3) ? 4 : (1 << l);
      end else if (m_cls[i]) begin
        m_cnt[i]--;
        if (m_cnt[i] == 0) begin m_open[i] = 0; m_cls[i] = 0; end
      end
    end
    if (cc != 0) begin
      e_bank = b;
      e_ap = (cc == 2 || cc == 3) ? a[8] : 1'b0;
    end
    if (cc == 1) e_row = a;
    if (cc == 2 || cc == 3) e_col = {a[9], a[7:0]};
  endtask

  task automatic step(logic c, logic [2:0] p, logic k, logic [11:0] a, logic [1:0] b, logic [1:0] l);
    cs_n = c; {ras_n, cas_n, we_n} = p; cke = k; addr = a; ba = b; bl = l;
    @(posedge clk);
    model(c, p, k, a, b, l);
    @(negedge clk);
    chk(cmd == 3'(e_cmd), tag, "cmd", 48'(cmd), 48'(e_cmd));
    chk(err == e_err, tag, "err", 48'(err), 48'(e_err));
    chk(bopen == exp_open() && rows == exp_rows(), tag, "banks",
        {bopen, rows[43:0]}, {exp_open(), exp_rows()[43:0]});
    chk(bank == e_bank && row == e_row && col == e_col && ap == e_ap, "R3", "addr outs",
        {bank, row, col, ap}, {e_bank, e_row, e_col, e_ap});
  endtask

  task automatic op(logic [2:0] p, logic [1:0] b, logic [11:0] a, logic [1:0] l);
    step(1'b0, p, 1'b1, a, b, l);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    m_ckep = 1; e_cmd = 0; e_err = 0; e_ap = 0; e_bank = 0; e_row = 0; e_col = 0;
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_cls[i] = 0; m_cnt[i] = 0; m_row[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd == 3'd0 && err == 1'b0, "R11", "reset outs", {cmd, err}, 48'd0);
    chk(bopen == 4'd0 && rows == 48'd0, "R11", "reset banks", {bopen, rows[43:0]}, 48'd0);

    op(P_ACT, 2'd1, 12'hABC, 2'd1);
    op(P_ACT, 2'd1, 12'h123, 2'd1);
    op(P_RD,  2'd2, 12'h055, 2'd1);
    op(P_WR,  2'd1, 12'h3A5, 2'd1);
    op(P_RD,  2'd1, 12'h000, 2'd1);
    op(P_NOP, 2'd0, 12'h000, 2'd1);
    op(P_NOP, 2'd0, 12'h000, 2'd1);
    op(P_ACT, 2'd0, 12'h005, 2'd0);
    op(P_PRE, 2'd0, 12'h000, 2'd0);
    op(P_PRE, 2'd0, 12'h000, 2'd0);
    op(P_ACT, 2'd0, 12'h0F0, 2'd0);
    op(P_ACT, 2'd3, 12'hF0F, 2'd0);
    op(P_PRE, 2'd2, 12'h100, 2'd0);
    step(1'b1, P_ACT, 1'b1, 12'h777, 2'd2, 2'd0);
    op(P_ACT, 2'd2, 12'h222, 2'd0);
    step(1'b0, P_NOP, 1'b0, 12'h000, 2'd0, 2'd0);
    op(P_ACT, 2'd3, 12'h333, 2'd0);
    step(1'b0, P_REF, 1'b0, 12'h000, 2'd0, 2'd0);
    op(P_REF, 2'd0, 12'h000, 2'd0);
    op(P_REF, 2'd0, 12'h000, 2'd0);
    for (int l = 0; l < 4; l++) begin
      op(P_ACT, 2'd3, 12'h400 + 12'(l), 2'(l));
      op(P_RD,  2'd3, 12'h1FF, 2'(l));
      op(P_ACT, 2'd3, 12'h000, 2'(l));
      for (int n = 0; n < 5; n++) op(P_NOP, 2'd0, 12'h000, 2'(l));
    end
    op(P_ACT, 2'd2, 12'h0AA, 2'd2);
    op(P_WR,  2'd2, 12'h100, 2'd2);
    step(1'b0, P_NOP, 1'b0, 12'h000, 2'd0, 2'd2);
    op(P_NOP, 2'd0, 12'h000, 2'd2);
    op(P_NOP, 2'd0, 12'h000, 2'd2);
    op(P_PRE, 2'd2, 12'h000, 2'd2);
    op(P_ACT, 2'd2, 12'h0BB, 2'd2);

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] p;
      int r = $urandom % 20;
      if (r < 5) p = P_ACT;
      else if (r < 9) p = P_RD;
      else if (r < 13) p = P_WR;
      else if (r < 15) p = P_PRE;
      else if (r < 16) p = P_REF;
      else if (r < 18) p = P_NOP;
      else p = 3'($urandom % 8);
      step(1'($urandom % 8 == 0), p, 1'($urandom % 10 != 0),
           12'($urandom), 2'($urandom), 2'((i / 200) % 4));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule